// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer with Watchdog

The block is a register-mapped timer peripheral. A shared 16-bit prescaler counts down by one on every cycle in which `tick_en` is high. Each time its count reaches zero it reloads and emits a one-cycle timing pulse. Four 16-bit sub-timers count that pulse. Any sub-timer after the first can instead be chained, so that it counts the underflows of the sub-timer just before it. This builds wider or cascaded intervals.

On underflow, a sub-timer either reloads from its own reload register or disables itself and stops. It can also latch a pending flag and pulse its own interrupt line for one cycle. The last sub-timer leaves reset already running with its interrupt enabled, so it acts as a watchdog. Software must either reprogram it or keep reloading it. Registers are reached over a plain single-cycle word port. Reads are combinational and writes take effect at the next clock edge.

Top module: `prescaled_timer_bank`

## Requirements
- R1: After reset, the prescaler count, the prescaler reload and every field of sub-timers 1 to 3 read 0. Sub-timer 4 reads count 0xFFFF and reload 0xFFFF. Its control reads 0x0B, meaning enable, restart and interrupt enable are set.
- R2: Address map in bytes. 0x00 is the prescaler count, 0x04 the prescaler reload, and 0x08 a read-only word holding the number of sub-timers (4). Sub-timer n (1..4) sits at 0x10*n, with count at +0x0, reload at +0x4, control at +0x8, and +0xC reading 0.
- R3: Control bits are: bit0 enable, bit1 restart, bit2 load, bit3 interrupt enable, bit4 pending, bit5 chain, bit6 halt. A control write changes only bits 0, 1, 3 and 5 (mask 0x2B). Bits 2 and 6 always read 0.
- R4: A control write with bit2 set copies the reload register into the count in the same edge.
- R5: A control write with bit4 = 0 clears the pending flag, and bit4 = 1 leaves it unchanged. A pending flag set by an underflow in the same cycle as a clearing write stays set.
- R6: The prescaler changes only on cycles with `tick_en` high, and then decrements. When the decremented value is 0 it loads the prescaler reload and issues a pulse. A count of 0 therefore wraps to 0xFFFF without a pulse.
- R7: An enabled, unchained sub-timer decrements once per prescaler pulse. A disabled sub-timer holds its count.
- R8: A sub-timer underflows when it is stepped while its count is 0. With restart set, it then loads its reload value and stays enabled.
- R9: On underflow with restart clear, the count becomes 0xFFFF and the enable bit clears. No further decrements occur.
- R10: On underflow with interrupt enable set, `irq_o` bit n-1 (interrupt line 7+n for sub-timer n) is high for exactly the cycle of the underflow, and pending sets. With interrupt enable clear, there is no pulse.
- R11: A sub-timer 2 to 4 with the chain bit set steps only on the underflow of the previous sub-timer, in the same cycle, and ignores prescaler pulses. The chain bit has no effect on sub-timer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the prescaler by one step |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one register per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 4 | One interrupt pulse line per sub-timer |

## Verification
The reload, stop and hold properties only describe cycles in which the checked sub-timer's count and control registers are not being written. A write in the same edge takes priority over the timer update, so those cycles are excluded. The prescaler reload property likewise excludes writes to the prescaler count. The stimulus performs every register access with `tick_en` low, except for one directed collision between an underflow and a pending-clear write. That collision checks the R5 priority at the ports. The stimulus also sets prescaler phase and sub-timer counts by writing them explicitly, so that every expected pulse falls on a known tick.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
    parameter int unsigned CNT_W = 16;

    localparam int unsigned CB_EN = 0;
    localparam int unsigned CB_RS = 1;
    localparam int unsigned CB_LD = 2;
    localparam int unsigned CB_IE = 3;
    localparam int unsigned CB_IP = 4;
    localparam int unsigned CB_CH = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        cnt_t rld;
    } presc_st_t;

    typedef struct packed {
        cnt_t cnt;
        cnt_t rld;
        logic en;
        logic rs;
        logic ie;
        logic ip;
        logic ch;
    } chan_st_t;
endpackage

// File: rtl/ptb_prescaler.sv
`timescale 1ns/1ps
module ptb_prescaler
    import ptb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wr_cnt,
    input  logic wr_rld,
    input  cnt_t wdata,
    output cnt_t cnt_o,
    output cnt_t rld_o,
    output logic pulse_o
);
    presc_st_t s_d, s_q;
    cnt_t      dec;

    always_comb begin
        s_d     = s_q;
        pulse_o = 1'b0;
        dec     = s_q.cnt - 1'b1;
        if (tick_en) begin
            if (dec == '0) begin
                pulse_o  = 1'b1;
                s_d.cnt  = s_q.rld;
            end else begin
                s_d.cnt  = dec;
            end
        end
        if (wr_cnt) s_d.cnt = wdata;
        if (wr_rld) s_d.rld = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign rld_o = s_q.rld;

    // R6
    presc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !wr_cnt) |=> (s_q.cnt == $past(s_q.rld)));
    // R6
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_cnt) |=> $stable(s_q.cnt));
endmodule

// File: rtl/ptb_channel.sv
`timescale 1ns/1ps
module ptb_channel
    import ptb_pkg::*;
#(
    parameter bit IS_WDOG  = 1'b0,
    parameter bit HAS_PREV = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presc_pulse,
    input  logic       prev_uf,
    input  logic       wr_cnt,
    input  logic       wr_rld,
    input  logic       wr_ctl,
    input  cnt_t       wdata,
    output cnt_t       cnt_o,
    output cnt_t       rld_o,
    output logic [7:0] ctl_o,
    output logic       uf_o,
    output logic       irq_o
);
    localparam chan_st_t RST_VAL = IS_WDOG ?
        chan_st_t'{cnt: '1, rld: '1, en: 1'b1, rs: 1'b1, ie: 1'b1, ip: 1'b0, ch: 1'b0} :
        chan_st_t'('0);

    chan_st_t s_d, s_q;
    logic     step;

    always_comb begin
        s_d   = s_q;
        step  = s_q.en && ((HAS_PREV && s_q.ch) ? prev_uf : presc_pulse);
        uf_o  = step && (s_q.cnt == '0);
        irq_o = uf_o && s_q.ie;
        if (step) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (uf_o) begin
                if (s_q.rs) begin
                    s_d.cnt = s_q.rld;
                end else begin
                    s_d.cnt = '1;
                    s_d.en  = 1'b0;
                end
                if (s_q.ie) s_d.ip = 1'b1;
            end
        end
        if (wr_rld) s_d.rld = wdata;
        if (wr_cnt) s_d.cnt = wdata;
        if (wr_ctl) begin
            s_d.en = wdata[CB_EN];
            s_d.rs = wdata[CB_RS];
            s_d.ie = wdata[CB_IE];
            s_d.ch = wdata[CB_CH];
            if (wdata[CB_LD]) s_d.cnt = s_q.rld;
            if (!wdata[CB_IP] && !irq_o) s_d.ip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign rld_o = s_q.rld;
    assign ctl_o = {2'b00, s_q.ch, s_q.ip, s_q.ie, 1'b0, s_q.rs, s_q.en};

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.en && !wr_cnt && !wr_ctl) |=> $stable(s_q.cnt));
    // R8
    restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && s_q.rs && !wr_cnt && !wr_ctl) |=> (s_q.cnt == $past(s_q.rld) && s_q.en));
    // R9
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && !s_q.rs && !wr_cnt && !wr_ctl) |=> (!s_q.en && s_q.cnt == '1));
    // R10
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> s_q.ip);
endmodule

// File: rtl/prescaled_timer_bank.sv
`timescale 1ns/1ps
module prescaled_timer_bank
    import ptb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int unsigned SLOT_LSB = 4;
    localparam int unsigned SLOT_W   = ADDR_W - SLOT_LSB;
    localparam int unsigned WDOG_IDX = NUM_CH - 1;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        fld;
    logic              glob_sel;
    cnt_t              wval;
    cnt_t              p_cnt, p_rld;
    logic              p_pulse;
    logic [NUM_CH-1:0] uf, wr_c, wr_r, wr_k;
    cnt_t              ch_cnt [NUM_CH];
    cnt_t              ch_rld [NUM_CH];
    logic [7:0]        ch_ctl [NUM_CH];

    assign slot     = reg_addr[ADDR_W-1:SLOT_LSB];
    assign fld      = reg_addr[3:2];
    assign glob_sel = (slot == '0);
    assign wval     = reg_wdata[CNT_W-1:0];

    ptb_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_cnt  (reg_wr && glob_sel && fld == 2'd0),
        .wr_rld  (reg_wr && glob_sel && fld == 2'd1),
        .wdata   (wval),
        .cnt_o   (p_cnt),
        .rld_o   (p_rld),
        .pulse_o (p_pulse)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic prev;
        logic sel;
        if (g == 0) begin : g_first
            assign prev = 1'b0;
        end else begin : g_next
            assign prev = uf[g-1];
        end
        assign sel     = (slot == SLOT_W'(g + 1));
        assign wr_c[g] = reg_wr && sel && fld == 2'd0;
        assign wr_r[g] = reg_wr && sel && fld == 2'd1;
        assign wr_k[g] = reg_wr && sel && fld == 2'd2;

        ptb_channel #(
            .IS_WDOG  (g == WDOG_IDX),
            .HAS_PREV (g != 0)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .presc_pulse (p_pulse),
            .prev_uf     (prev),
            .wr_cnt      (wr_c[g]),
            .wr_rld      (wr_r[g]),
            .wr_ctl      (wr_k[g]),
            .wdata       (wval),
            .cnt_o       (ch_cnt[g]),
            .rld_o       (ch_rld[g]),
            .ctl_o       (ch_ctl[g]),
            .uf_o        (uf[g]),
            .irq_o       (irq_o[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (glob_sel) begin
            case (fld)
                2'd0:    reg_rdata = DATA_W'(p_cnt);
                2'd1:    reg_rdata = DATA_W'(p_rld);
                2'd2:    reg_rdata = DATA_W'(NUM_CH);
                default: reg_rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot == SLOT_W'(i + 1)) begin
                case (fld)
                    2'd0:    reg_rdata = DATA_W'(ch_cnt[i]);
                    2'd1:    reg_rdata = DATA_W'(ch_rld[i]);
                    2'd2:    reg_rdata = DATA_W'(ch_ctl[i]);
                    default: reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/prescaled_timer_bank_test.sv
`timescale 1ns/1ps
module prescaled_timer_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    prescaled_timer_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // n ticks; irq bit ch must be high only on tick number fire_at (0 = never)
    task automatic run_ticks(input string req, input int n, input int ch, input int fire_at);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            #1;
            chk(req, 32'(irq_o[ch]), 32'(k == fire_at));
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 presc cnt", 8'h00, 32'h0);
        rd_chk("R1 presc rld", 8'h04, 32'h0);
        rd_chk("R2 config", 8'h08, 32'd4);
        rd_chk("R1 t1 cnt", 8'h10, 32'h0);
        rd_chk("R1 t2 rld", 8'h24, 32'h0);
        rd_chk("R1 t3 ctl", 8'h38, 32'h0);
        rd_chk("R1 t4 cnt", 8'h40, 32'hFFFF);
        rd_chk("R1 t4 rld", 8'h44, 32'hFFFF);
        rd_chk("R1 t4 ctl", 8'h48, 32'h0B);
        rd_chk("R2 latch slot", 8'h4C, 32'h0);
        wr(8'h48, 32'h0);
        rd_chk("R1 t4 disabled", 8'h48, 32'h0);
    endtask

    task automatic t_presc;
        run_ticks("R6 wrap no pulse", 1, 0, 0);
        rd_chk("R6 wrap", 8'h00, 32'hFFFF);
        wr(8'h00, 32'd5);
        repeat (3) @(negedge clk);
        rd_chk("R6 hold idle", 8'h00, 32'd5);
        run_ticks("R6 step", 1, 0, 0);
        rd_chk("R6 step", 8'h00, 32'd4);
        wr(8'h04, 32'd2);
        rd_chk("R6 rld", 8'h04, 32'd2);
    endtask

    task automatic t_mask_load;
        wr(8'h14, 32'd5);
        wr(8'h18, 32'hFF);
        rd_chk("R3 mask", 8'h18, 32'h2B);
        rd_chk("R4 load", 8'h10, 32'd5);
        wr(8'h18, 32'h0);
        wr(8'h10, 32'd9);
        rd_chk("R2 cnt write", 8'h10, 32'd9);
        wr(8'h18, 32'h04);
        rd_chk("R4 load reads 0", 8'h18, 32'h0);
        rd_chk("R4 load value", 8'h10, 32'd5);
    endtask

    task automatic t_restart;
        wr(8'h00, 32'd2);
        wr(8'h14, 32'd3);
        wr(8'h18, 32'h04);
        wr(8'h18, 32'h0B);
        run_ticks("R10 R7 irq tick8", 8, 0, 8);
        rd_chk("R8 reload", 8'h10, 32'd3);
        rd_chk("R8 R10 ctl pend", 8'h18, 32'h1B);
        wr(8'h18, 32'h1B);
        rd_chk("R5 write1 keeps", 8'h18, 32'h1B);
        wr(8'h18, 32'h0B);
        rd_chk("R5 write0 clears", 8'h18, 32'h0B);
        wr(8'h18, 32'h0);
    endtask

    task automatic t_stop;
        wr(8'h00, 32'd2);
        wr(8'h14, 32'd1);
        wr(8'h18, 32'h04);
        wr(8'h18, 32'h01);
        run_ticks("R10 no irq ie0", 6, 0, 0);
        rd_chk("R9 cnt", 8'h10, 32'hFFFF);
        rd_chk("R9 en clr", 8'h18, 32'h0);
        run_ticks("R7 disabled", 4, 0, 0);
        rd_chk("R7 hold", 8'h10, 32'hFFFF);
    endtask

    task automatic t_chain;
        wr(8'h00, 32'd2);
        wr(8'h14, 32'd1);
        wr(8'h18, 32'h04);
        wr(8'h18, 32'h03);
        wr(8'h24, 32'd1);
        wr(8'h28, 32'h04);
        wr(8'h28, 32'h2B);
        run_ticks("R11 chain", 2, 1, 0);
        rd_chk("R11 t2 ignores pulse", 8'h20, 32'd1);
        rd_chk("R7 t1 stepped", 8'h10, 32'd0);
        run_ticks("R11 chain irq", 6, 1, 6);
        rd_chk("R11 t2 reload", 8'h20, 32'd1);
        wr(8'h18, 32'h0);
        wr(8'h28, 32'h0);
    endtask

    task automatic t_chain_first;
        wr(8'h00, 32'd2);
        wr(8'h14, 32'd0);
        wr(8'h18, 32'h04);
        wr(8'h18, 32'h2B);
        run_ticks("R11 t1 chain ignored", 2, 0, 2);
        run_ticks("R11 t1 chain again", 2, 0, 2);
        wr(8'h18, 32'h0);
    endtask

    task automatic t_wdog;
        wr(8'h00, 32'd2);
        wr(8'h44, 32'd0);
        wr(8'h48, 32'h04);
        wr(8'h48, 32'h0B);
        run_ticks("R10 line 11", 2, 3, 2);
        wr(8'h48, 32'h0);
    endtask

    task automatic t_pend_race;
        wr(8'h00, 32'd1);
        wr(8'h14, 32'd0);
        wr(8'h18, 32'h04);
        wr(8'h18, 32'h0B);
        @(negedge clk);
        tick_en = 1'b1;
        reg_addr = 8'h18; reg_wdata = 32'h0B; reg_wr = 1'b1;
        #1;
        chk("R5 race irq", 32'(irq_o[0]), 32'd1);
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        rd_chk("R5 set wins", 8'h18, 32'h1B);
        wr(8'h18, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_presc;
        t_mask_load;
        t_restart;
        t_stop;
        t_chain;
        t_chain_first;
        t_wdog;
        t_pend_race;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule